// File: doc/BRIEF.md
# Configurable SPI Master/Slave Channel Controller

This block runs one serial peripheral interface channel, either as the clock-driving master or as a slave that follows an external clock and chip select. Software drives it over a small register bus. A 7-bit control word sets the role, clock polarity, clock phase and whether the serial clock pin is driven. It also sets how completion is reported: plain polling, an interrupt line, or a DMA request line. Every transfer is one 8-bit byte, most significant bit first. Data is sent and received at the same time.

In master mode, a write to the transmit data register starts a transfer. The serial clock then runs at the system clock divided by 2×(divider+1). An automatic fill mode lets software receive without writing dummy bytes. In that mode, each read of the receive register in master mode starts the next transfer, and the block sends all ones. A slave in this mode sends all ones when no byte was loaded before chip select fell.

In slave mode, the transmit byte must be written before chip select goes low. The slave's clock, chip select and data inputs pass through two-stage synchronizers. The external master must therefore hold each clock phase for several system clocks.

Top module: `spi_xfer_unit`

## Requirements
- R1: After reset, the control register reads 0x00 and the divider reads 0x00. The status register (address 1) reads 0x01: bit 0 is ready, bit 1 is write collision, bit 2 is transfer done. Chip select output is high, SCK output is low, and the interrupt and DMA request outputs are low.
- R2: The control register is at address 0. Its fields are: service mode [6:5], SCK drive enable [4], master [3], clock polarity [2], clock phase [1], automatic fill [0]. It reads back as written, and bit 7 always reads 0.
- R3: In master mode, a write to address 3 starts an 8-bit MSB-first transfer. Chip select output is low for the whole transfer. Status ready clears at the start and sets when the byte is complete.
- R4: The divider is at address 2. Each SCK half period lasts divider+1 system clocks. Status ready returns exactly 16×(divider+1) clocks after the write clock edge.
- R5: With polarity 0, SCK idles low. With polarity 1, SCK idles high. A master transfer with the clock driven makes exactly 16 SCK transitions and leaves SCK at its idle level.
- R6: With phase 0, input data is sampled on odd SCK transitions (1st, 3rd, …). With phase 1, data changes on odd transitions and is sampled on even transitions.
- R7: In master mode with SCK drive enable 0, SCK stays at its idle level, and the transfer still completes with the correct timing and data.
- R8: Service mode encodings are 00 polling, 01 interrupt and 10 DMA. Transfer done raises the interrupt output only in mode 01 and the DMA request only in mode 10; polling raises neither. A read of the receive register clears the request.
- R9: Address 4 returns the last received byte.
- R10: A transmit write during a transfer sets the collision flag and is otherwise ignored. A status read with the read strobe clears the flag.
- R11: With automatic fill 1 in master mode, a receive-register read while idle starts a transfer that sends 0xFF. With automatic fill 0, such a read starts nothing.
- R12: In slave mode, a byte written before chip select falls is sent MSB first on the slave data output, and the byte on the slave data input is received. With automatic fill 1 and no byte loaded, the slave sends 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 3 | Register address |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (for read side effects) |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr |
| sck_o | output | 1 | Serial clock driven in master mode |
| sck_oe | output | 1 | Serial clock output enable |
| sck_i | input | 1 | Serial clock from an external master |
| mosi_o | output | 1 | Master data output |
| mosi_i | input | 1 | Slave data input |
| miso_o | output | 1 | Slave data output |
| miso_i | input | 1 | Master data input |
| cs_n_o | output | 1 | Chip select driven in master mode, active low |
| cs_n_i | input | 1 | Chip select from an external master, active low |
| irq_o | output | 1 | Transfer-done interrupt |
| dma_req_o | output | 1 | Transfer-done DMA request |

## Verification
The bench uses the default parameters: 8-bit data, an 8-bit divider and two synchronizer stages. It runs master transfers with divider values 0 and 3, so both the shortest half period and a multi-cycle half period are measured against the 16×(divider+1) rule. It also covers both clock polarities and both phases. For the phase checks, a bench-side slave changes its data only at the transition the selected format calls for, so a sample on the wrong edge shows up as a wrong received byte. Slave transfers are clocked with eight system clocks per phase, which absorbs the synchronizer delay.

// File: rtl/spi_xfer_pkg.sv
package spi_xfer_pkg;

    localparam int BUS_W  = 8;
    localparam int CTRL_W = 7;

    localparam logic [2:0] ADR_CTRL = 3'd0;
    localparam logic [2:0] ADR_STAT = 3'd1;
    localparam logic [2:0] ADR_DIV  = 3'd2;
    localparam logic [2:0] ADR_TXD  = 3'd3;
    localparam logic [2:0] ADR_RXD  = 3'd4;

    typedef enum logic [1:0] {
        SVC_POLL = 2'b00,
        SVC_IRQ  = 2'b01,
        SVC_DMA  = 2'b10,
        SVC_RSVD = 2'b11
    } svc_mode_e;

    // Packed so that the field positions match the register bits.
    typedef struct packed {
        svc_mode_e svc;
        logic      clk_en;
        logic      is_master;
        logic      cpol;
        logic      cpha;
        logic      auto_fill;
    } ctrl_t;

    function automatic ctrl_t ctrl_decode(input logic [BUS_W-1:0] d);
        return ctrl_t'(d[CTRL_W-1:0]);
    endfunction

    function automatic logic [BUS_W-1:0] ctrl_encode(input ctrl_t c);
        return {1'b0, c};
    endfunction

endpackage

// File: rtl/spi_xfer_sync.sv
module spi_xfer_sync #(
    parameter int          W       = 3,
    parameter int          STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    for (genvar b = 0; b < W; b++) begin : g_bit
        logic [STAGES-1:0] chain;
        always_ff @(posedge clk) begin
            if (rst) chain <= {STAGES{RST_VAL[b]}};
            else     chain <= {chain[STAGES-2:0], d[b]};
        end
        assign q[b] = chain[STAGES-1];
    end
endmodule

// File: rtl/spi_xfer_clkgen.sv
module spi_xfer_clkgen #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    logic [DIV_W-1:0] cnt;

    assign tick = run && (cnt == div);

    always_ff @(posedge clk) begin
        if (rst || !run)    cnt <= '0;
        else if (cnt == div) cnt <= '0;
        else                cnt <= cnt + 1'b1;
    end

    AST_TICK_GAP: assert property (@(posedge clk) disable iff (rst)
        (tick && div != '0 && $stable(div)) |=> !tick); // R4
endmodule

// File: rtl/spi_xfer_engine.sv
module spi_xfer_engine #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              master,
    input  logic              cpol,
    input  logic              cpha,
    input  logic              m_start,
    input  logic [DATA_W-1:0] m_byte,
    input  logic              m_tick,
    input  logic              s_sck,
    input  logic              s_cs_n,
    input  logic [DATA_W-1:0] s_byte,
    input  logic              din,
    output logic              busy,
    output logic              started,
    output logic              done,
    output logic [DATA_W-1:0] rx_byte,
    output logic              sck_q,
    output logic              shift_bit
);
    localparam int N_EDGE = 2 * DATA_W;
    localparam int EW     = $clog2(N_EDGE + 1);

    logic [EW-1:0]     edge_cnt, nxt;
    logic [DATA_W-1:0] tx_sr, rx_sr;
    logic              sck_prev, cs_prev;
    logic              s_start, s_abort, edge_ev, smp, sh, last;

    assign s_start = !master && !busy && cs_prev && !s_cs_n;
    assign started = m_start || s_start;
    assign s_abort = !master && busy && s_cs_n;
    assign edge_ev = busy && (master ? m_tick : (s_sck != sck_prev));
    assign nxt     = edge_cnt + 1'b1;
    assign smp     = nxt[0] != cpha;
    assign last    = nxt == EW'(N_EDGE);
    assign sh      = !smp && nxt != EW'(1) && !last;

    assign rx_byte   = rx_sr;
    assign shift_bit = tx_sr[DATA_W-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            busy     <= 1'b0;
            done     <= 1'b0;
            edge_cnt <= '0;
            tx_sr    <= '0;
            rx_sr    <= '0;
            sck_q    <= 1'b0;
            sck_prev <= 1'b0;
            cs_prev  <= 1'b1;
        end else begin
            sck_prev <= s_sck;
            cs_prev  <= s_cs_n;
            done     <= 1'b0;
            if (started) begin
                busy     <= 1'b1;
                edge_cnt <= '0;
                tx_sr    <= master ? m_byte : s_byte;
                sck_q    <= cpol;
            end else if (s_abort) begin
                busy <= 1'b0;
            end else if (edge_ev) begin
                edge_cnt <= nxt;
                sck_q    <= !sck_q;
                if (smp) rx_sr <= {rx_sr[DATA_W-2:0], din};
                if (sh)  tx_sr <= {tx_sr[DATA_W-2:0], 1'b0};
                if (last) begin
                    busy <= 1'b0;
                    done <= 1'b1;
                end
            end
        end
    end

    AST_EDGE_LIMIT: assert property (@(posedge clk) disable iff (rst)
        busy |-> edge_cnt < EW'(N_EDGE)); // R3
    AST_START_BUSY: assert property (@(posedge clk) disable iff (rst)
        m_start |=> busy); // R3
    AST_SCK_RETURNS: assert property (@(posedge clk) disable iff (rst)
        (done && $stable(cpol)) |-> (sck_q == cpol && !busy)); // R5
endmodule

// File: rtl/spi_xfer_regs.sv
module spi_xfer_regs
    import spi_xfer_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int DIV_W  = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [2:0]        bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [BUS_W-1:0]  bus_rdata,
    input  logic              busy,
    input  logic              started,
    input  logic              done,
    input  logic [DATA_W-1:0] rx_byte,
    output ctrl_t             ctrl,
    output logic [DIV_W-1:0]  div_q,
    output logic              m_start,
    output logic [DATA_W-1:0] m_byte,
    output logic [DATA_W-1:0] s_byte,
    output logic              irq_o,
    output logic              dma_req_o
);
    logic              coll, done_flag, pend;
    logic [DATA_W-1:0] tx_buf;
    logic              wr_tx, rd_rx, rd_st;

    assign wr_tx = bus_wr && bus_addr == ADR_TXD;
    assign rd_rx = bus_rd && bus_addr == ADR_RXD;
    assign rd_st = bus_rd && bus_addr == ADR_STAT;

    assign m_start = ctrl.is_master && !busy && (wr_tx || (rd_rx && ctrl.auto_fill));
    assign m_byte  = wr_tx ? DATA_W'(bus_wdata) : '1;
    assign s_byte  = (!pend && ctrl.auto_fill) ? '1 : tx_buf;

    assign irq_o     = done_flag && ctrl.svc == SVC_IRQ;
    assign dma_req_o = done_flag && ctrl.svc == SVC_DMA;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl      <= '0;
            div_q     <= '0;
            coll      <= 1'b0;
            done_flag <= 1'b0;
            pend      <= 1'b0;
            tx_buf    <= '0;
        end else begin
            if (bus_wr && bus_addr == ADR_CTRL) ctrl  <= ctrl_decode(bus_wdata);
            if (bus_wr && bus_addr == ADR_DIV)  div_q <= DIV_W'(bus_wdata);

            if (wr_tx && busy) coll <= 1'b1;
            else if (rd_st)    coll <= 1'b0;

            if (started) pend <= 1'b0;
            if (wr_tx && !busy && !ctrl.is_master) begin
                tx_buf <= DATA_W'(bus_wdata);
                pend   <= 1'b1;
            end

            if (done)                             done_flag <= 1'b1;
            else if (started || rd_rx || wr_tx)   done_flag <= 1'b0;
        end
    end

    always_comb begin
        case (bus_addr)
            ADR_CTRL: bus_rdata = ctrl_encode(ctrl);
            ADR_STAT: bus_rdata = {{(BUS_W-3){1'b0}}, done_flag, coll, !busy};
            ADR_DIV:  bus_rdata = BUS_W'(div_q);
            ADR_RXD:  bus_rdata = BUS_W'(rx_byte);
            default:  bus_rdata = '0;
        endcase
    end

    AST_COLL_FLAG: assert property (@(posedge clk) disable iff (rst)
        (wr_tx && busy) |=> coll); // R10
    AST_REQ_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (rd_rx && !done) |=> (!irq_o && !dma_req_o)); // R8
endmodule

// File: rtl/spi_xfer_unit.sv
module spi_xfer_unit
    import spi_xfer_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int DIV_W       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [2:0] bus_addr,
    input  logic       bus_wr,
    input  logic       bus_rd,
    input  logic [7:0] bus_wdata,
    output logic [7:0] bus_rdata,
    output logic       sck_o,
    output logic       sck_oe,
    input  logic       sck_i,
    output logic       mosi_o,
    input  logic       mosi_i,
    output logic       miso_o,
    input  logic       miso_i,
    output logic       cs_n_o,
    input  logic       cs_n_i,
    output logic       irq_o,
    output logic       dma_req_o
);
    ctrl_t             ctrl;
    logic [DIV_W-1:0]  div_q;
    logic              m_start, tick, busy, started, done, sck_q, shift_bit, din;
    logic [DATA_W-1:0] m_byte, s_byte, rx_byte;
    logic [2:0]        pins_s;

    spi_xfer_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b010)) u_sync (
        .clk(clk), .rst(rst), .d({sck_i, cs_n_i, mosi_i}), .q(pins_s)
    );

    spi_xfer_regs #(.DATA_W(DATA_W), .DIV_W(DIV_W)) u_regs (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .busy(busy), .started(started),
        .done(done), .rx_byte(rx_byte), .ctrl(ctrl), .div_q(div_q), .m_start(m_start),
        .m_byte(m_byte), .s_byte(s_byte), .irq_o(irq_o), .dma_req_o(dma_req_o)
    );

    spi_xfer_clkgen #(.DIV_W(DIV_W)) u_clkgen (
        .clk(clk), .rst(rst), .run(busy && ctrl.is_master), .div(div_q), .tick(tick)
    );

    assign din = ctrl.is_master ? miso_i : pins_s[0];

    spi_xfer_engine #(.DATA_W(DATA_W)) u_engine (
        .clk(clk), .rst(rst), .master(ctrl.is_master), .cpol(ctrl.cpol), .cpha(ctrl.cpha),
        .m_start(m_start), .m_byte(m_byte), .m_tick(tick), .s_sck(pins_s[2]),
        .s_cs_n(pins_s[1]), .s_byte(s_byte), .din(din), .busy(busy), .started(started),
        .done(done), .rx_byte(rx_byte), .sck_q(sck_q), .shift_bit(shift_bit)
    );

    assign sck_o  = (ctrl.is_master && ctrl.clk_en && busy) ? sck_q : ctrl.cpol;
    assign sck_oe = ctrl.is_master && ctrl.clk_en;
    assign mosi_o = ctrl.is_master ? shift_bit : 1'b0;
    assign miso_o = ctrl.is_master ? 1'b0 : shift_bit;
    assign cs_n_o = !(ctrl.is_master && busy);

    AST_IRQ_IDLE: assert property (@(posedge clk) disable iff (rst)
        (irq_o || dma_req_o) |-> !busy); // R8
endmodule

// File: tb/spi_xfer_unit_tb.sv
module spi_xfer_unit_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] bus_addr = '0;
    logic       bus_wr = 1'b0, bus_rd = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       sck_o, sck_oe, mosi_o, miso_o, cs_n_o, irq_o, dma_req_o;
    logic       sck_i = 1'b0, mosi_i = 1'b0, cs_n_i = 1'b1;
    logic       loop = 1'b1, miso_drv = 1'b0;
    logic       miso_i;
    int         errors = 0, checks = 0, cycles = 0;

    localparam logic [2:0] A_CTRL = 3'd0, A_STAT = 3'd1, A_DIV = 3'd2, A_TXD = 3'd3, A_RXD = 3'd4;

    assign miso_i = loop ? mosi_o : miso_drv;

    always #2.5 clk = ~clk;

    spi_xfer_unit u_dut (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .sck_o(sck_o), .sck_oe(sck_oe),
        .sck_i(sck_i), .mosi_o(mosi_o), .mosi_i(mosi_i), .miso_o(miso_o), .miso_i(miso_i),
        .cs_n_o(cs_n_o), .cs_n_i(cs_n_i), .irq_o(irq_o), .dma_req_o(dma_req_o)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000) begin
            errors = errors + 1;
            $display("FAIL watchdog: actual=%0d expected<=150000 cycles", cycles);
            $display("Result: errors=%0d of %0d checks", errors, checks + 1);
            $finish;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic peek_stat(output logic [7:0] v);
        bus_addr = A_STAT;
        #1 v = bus_rdata;
    endtask

    task automatic wait_ready();
        logic [7:0] s;
        for (int i = 0; i < 5000; i++) begin
            @(negedge clk);
            peek_stat(s);
            if (s[0]) break;
        end
    endtask

    // Master transfer; measures cycles to ready, SCK transitions, chip select.
    task automatic master_xfer(input logic [7:0] tx, input logic cpha_v, input logic [7:0] pat,
                               output int cyc, output int edges, output logic cs_low);
        logic [7:0] s;
        logic       last_sck;
        int         idx;
        miso_drv = pat[7];
        last_sck = sck_o;
        edges = 0; cyc = 0; cs_low = 1'b0;
        bus_write(A_TXD, tx);
        for (int i = 0; i < 5000; i++) begin
            #1;
            if (!cs_n_o) cs_low = 1'b1;
            if (sck_o != last_sck) begin
                edges++;
                last_sck = sck_o;
                idx = cpha_v ? (edges == 0 ? 0 : (edges - 1) / 2) : edges / 2;
                if (idx < 8) miso_drv = pat[7 - idx];
            end
            peek_stat(s);
            if (s[0]) break;
            @(negedge clk);
            cyc++;
        end
    endtask

    task automatic t_reset();
        logic [7:0] v;
        bus_read(A_CTRL, v); chk("R1 ctrl", v, 8'h00);
        bus_read(A_DIV, v);  chk("R1 div", v, 8'h00);
        peek_stat(v);        chk("R1 status", v, 8'h01);
        chk("R1 cs_n", cs_n_o, 1);
        chk("R1 sck", sck_o, 0);
        chk("R1 irq/dma", {irq_o, dma_req_o}, 0);
    endtask

    task automatic t_ctrl_rw();
        logic [7:0] v;
        bus_write(A_CTRL, 8'h55); bus_read(A_CTRL, v); chk("R2 readback", v, 8'h55);
        bus_write(A_CTRL, 8'hFF); bus_read(A_CTRL, v); chk("R2 bit7 zero", v, 8'h7F);
        bus_write(A_CTRL, 8'h00);
    endtask

    task automatic t_master(input logic [7:0] ctl, input logic [7:0] dv, input logic [7:0] tx);
        int cyc, edges; logic csl; logic [7:0] v;
        loop = 1'b1;
        bus_write(A_DIV, dv);
        bus_write(A_CTRL, ctl);
        @(negedge clk); #1;
        chk("R5 idle sck before", sck_o, int'(ctl[2]));
        master_xfer(tx, ctl[1], 8'h00, cyc, edges, csl);
        chk("R4 transfer length", cyc, 16 * (dv + 1));
        chk("R3 cs low during", csl, 1);
        chk("R5 sck transitions", edges, 16);
        chk("R5 idle sck after", sck_o, int'(ctl[2]));
        chk("R8 poll no request", {irq_o, dma_req_o}, 0);
        bus_read(A_RXD, v); chk("R9 rx loopback", v, tx);
    endtask

    task automatic t_phase(input logic cpha_v, input logic [7:0] pat);
        int cyc, edges; logic csl; logic [7:0] v;
        loop = 1'b0;
        bus_write(A_DIV, 8'd1);
        bus_write(A_CTRL, cpha_v ? 8'h1A : 8'h18);
        master_xfer(8'h00, cpha_v, pat, cyc, edges, csl);
        bus_read(A_RXD, v); chk(cpha_v ? "R6 phase1 rx" : "R6 phase0 rx", v, pat);
        loop = 1'b1;
    endtask

    task automatic t_sck_off();
        int cyc, edges; logic csl; logic [7:0] v;
        bus_write(A_DIV, 8'd0);
        bus_write(A_CTRL, 8'h08);
        master_xfer(8'hC6, 1'b0, 8'h00, cyc, edges, csl);
        chk("R7 no sck edges", edges, 0);
        chk("R7 length", cyc, 16);
        bus_read(A_RXD, v); chk("R7 rx", v, 8'hC6);
    endtask

    task automatic t_requests();
        int cyc, edges; logic csl; logic [7:0] v;
        bus_write(A_DIV, 8'd0);
        bus_write(A_CTRL, 8'h38);
        master_xfer(8'h11, 1'b0, 8'h00, cyc, edges, csl);
        repeat (2) @(negedge clk);
        chk("R8 irq mode", {irq_o, dma_req_o}, 2'b10);
        bus_read(A_RXD, v); #1;
        chk("R8 irq cleared by rx read", irq_o, 0);
        bus_write(A_CTRL, 8'h58);
        master_xfer(8'h22, 1'b0, 8'h00, cyc, edges, csl);
        repeat (2) @(negedge clk);
        chk("R8 dma mode", {irq_o, dma_req_o}, 2'b01);
        bus_read(A_RXD, v); #1;
        chk("R8 dma cleared by rx read", dma_req_o, 0);
    endtask

    task automatic t_collision();
        logic [7:0] v;
        bus_write(A_DIV, 8'd3);
        bus_write(A_CTRL, 8'h18);
        bus_write(A_TXD, 8'h5A);
        repeat (5) @(negedge clk);
        bus_write(A_TXD, 8'hC3);
        peek_stat(v); chk("R10 collision set", v[1], 1);
        wait_ready();
        bus_read(A_RXD, v); chk("R10 second write ignored", v, 8'h5A);
        bus_read(A_STAT, v);
        peek_stat(v); chk("R10 collision cleared", v[1], 0);
    endtask

    task automatic t_auto();
        logic [7:0] v;
        bus_write(A_DIV, 8'd0);
        bus_write(A_CTRL, 8'h18);
        bus_read(A_RXD, v);
        repeat (3) @(negedge clk);
        peek_stat(v); chk("R11 no start without fill", v[0], 1);
        bus_write(A_CTRL, 8'h19);
        bus_read(A_RXD, v);
        peek_stat(v); chk("R11 read starts transfer", v[0], 0);
        wait_ready();
        bus_read(A_RXD, v); chk("R11 filler sent", v, 8'hFF);
        wait_ready();
    endtask

    task automatic t_slave(input logic [7:0] ctl, input logic load, input logic [7:0] tx,
                           input logic [7:0] mo, input logic [7:0] exp_out, input string tag);
        logic [7:0] got, v;
        bus_write(A_CTRL, ctl);
        if (load) bus_write(A_TXD, tx);
        @(negedge clk); cs_n_i = 1'b0;
        repeat (8) @(negedge clk);
        for (int b = 7; b >= 0; b--) begin
            mosi_i = mo[b];
            repeat (8) @(negedge clk);
            got[b] = miso_o;
            sck_i = 1'b1;
            repeat (8) @(negedge clk);
            sck_i = 1'b0;
        end
        repeat (8) @(negedge clk);
        cs_n_i = 1'b1;
        repeat (4) @(negedge clk);
        chk({tag, " miso byte"}, got, exp_out);
        bus_read(A_RXD, v); chk({tag, " rx byte"}, v, mo);
        peek_stat(v); chk({tag, " ready"}, v[0], 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_ctrl_rw();
        t_master(8'h18, 8'd0, 8'hA5);
        t_master(8'h1E, 8'd3, 8'h3C);
        t_phase(1'b0, 8'h96);
        t_phase(1'b1, 8'h69);
        t_sck_off();
        t_requests();
        t_collision();
        t_auto();
        t_slave(8'h00, 1'b1, 8'hB4, 8'h2D, 8'hB4, "R12 loaded");
        t_slave(8'h01, 1'b0, 8'h00, 8'h81, 8'hFF, "R12 fill");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule